// File: doc/BRIEF.md
# Transmit descriptor ring engine

This block scans a ring of sixteen transmit descriptors kept in system memory and turns every descriptor that software has handed over into a byte stream. A single pulse on the trigger input starts one pass over the ring. For each entry the pass reads the status byte. If the entry is ready, the pass reads the stored negative length, then reads that many bytes from the entry's fixed data buffer and delivers them on a ready/valid byte stream with first-byte and last-byte markers. Once the last byte is taken, the engine writes a completion code back into the status byte, advances its ring index and pulses a transmit-done flag.

Every memory access is a single-byte request on a request/response port. At most one request is outstanding at a time, and each request, read or write, is answered by exactly one response pulse. All addresses are offsets from a base input. With the default parameters, the descriptor ring starts 152 bytes above the base, with 8 bytes per entry. The per-entry data buffers of 1544 bytes each start 280 bytes above the base. While a stop input is held high, a trigger is ignored. A trigger that arrives during a pass is also ignored.

Top module: `txr_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, busy_o, tx_valid_o, mem_req_o and tint_o are 0 and idx_o is 0.
- R2: An entry is sent only when its status byte, at descriptor offset 2, reads exactly 0x83. Any other value, including 0x80, 0x82, 0x87, 0x93 and 0x03, is skipped: no bytes are sent for it and its status byte is left unchanged.
- R3: The length is formed from descriptor offset 4, which is the high byte, and offset 5, which is the low byte. The result N is a 16-bit two's-complement negative. The byte count is (~N + 1) mod 65536.
- R4: A byte count of 0, or any count above 1544, is replaced by 1544 before the buffer is read.
- R5: Entry e sends its bytes from base + 280 + 1544*e upward, in address order. tx_first_o is 1 only on the first byte and tx_last_o is 1 only on the final byte. While tx_valid_o is 1 and tx_ready_i is 0, the data and both markers hold steady and no memory request is made.
- R6: After the final byte of an entry is accepted, 0x03 is written to that entry's status byte. Then tint_o pulses for exactly one cycle and idx_o increases by one, wrapping modulo 16.
- R7: A pass that starts at index s examines entries s, s+1, ... modulo 16, and stops after entry s-2. Entry s-1 is not examined. Every ready entry among the 15 examined entries is sent, in ring order.
- R8: A trigger while stopped_i is 1 starts nothing: no memory request is made and busy_o stays 0. A trigger while busy_o is 1 does not start a further pass.
- R9: idx_o advances by one for each sent entry, not to the position of the entry sent. Skipped entries do not move it.
- R10: The status byte of entry e is at base + 152 + 8*e + 2. The completion write goes to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Start one pass over the ring |
| stopped_i | input | 1 | Controller stopped: triggers are ignored |
| base_i | input | AW | Base address of the descriptor/buffer area |
| mem_req_o | output | 1 | One-cycle memory request |
| mem_we_o | output | 1 | Request is a byte write |
| mem_addr_o | output | AW | Byte address of the request |
| mem_wdata_o | output | 8 | Write data |
| mem_rvalid_i | input | 1 | Response to the outstanding request |
| mem_rdata_i | input | 8 | Read data returned with the response |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_data_o | output | 8 | Stream byte |
| tx_first_o | output | 1 | First byte of an entry |
| tx_last_o | output | 1 | Final byte of an entry |
| tx_ready_i | input | 1 | Stream sink accepts the byte |
| tint_o | output | 1 | One-cycle pulse per released entry |
| busy_o | output | 1 | A pass is in progress |
| idx_o | output | RING_LOG | Current ring index |

## Verification
A single ready entry with a short length shows that the length is decoded correctly, that the buffer is addressed correctly and that the completion write-back works. A ring filled with near-miss status codes shows that readiness requires an exact match and not a bit test. It also shows that the index counts sent entries rather than following their positions. A pass whose ready entries wrap past index 15, and which includes a ready entry just before the start index, separates a full-ring walk from the required 15-entry walk. That same pass runs with a sink that keeps dropping ready, to expose any byte that is lost or changed while stalled. Lengths of 0, 1, exactly 1544 and 2000 separate the clamping limit from an off-by-one error. Triggers sent while stopped and while busy confirm that neither one starts a pass.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_STAT_RQ, S_STAT_WT, S_LENH_RQ, S_LENH_WT, S_LENL_RQ, S_LENL_WT,
    S_BYTE_RQ, S_BYTE_WT, S_BYTE_OUT, S_REL_RQ, S_REL_WT, S_STEP
  } walk_state_t;

  typedef enum logic [1:0] {A_STAT, A_LENH, A_LENL, A_BUF} addr_sel_t;

  localparam int          LEN_W     = 16;
  localparam int          OFS_STAT  = 2;
  localparam int          OFS_LENH  = 4;
  localparam int          OFS_LENL  = 5;
  localparam logic [7:0]  READY_CODE = 8'h83;
  localparam logic [7:0]  DONE_CODE  = 8'h03;
endpackage

// File: rtl/txr_addr_gen.sv
module txr_addr_gen import txr_pkg::*; #(
  parameter int AW         = 24,
  parameter int RING_LOG   = 4,
  parameter int DESC_BYTES = 8,
  parameter int RING_OFS   = 152,
  parameter int BUF_OFS    = 280,
  parameter int BUF_BYTES  = 1544
) (
  input  logic [AW-1:0]       base_i,
  input  logic [RING_LOG-1:0] entry_i,
  input  addr_sel_t           sel_i,
  input  logic [LEN_W-1:0]    boff_i,
  output logic [AW-1:0]       addr_o
);
  localparam logic [AW-1:0] RING_A = AW'(RING_OFS);
  localparam logic [AW-1:0] BUF_A  = AW'(BUF_OFS);
  localparam logic [AW-1:0] DESC_A = AW'(DESC_BYTES);
  localparam logic [AW-1:0] BSZ_A  = AW'(BUF_BYTES);

  logic [AW-1:0] entry_w;
  logic [AW-1:0] desc_base;
  logic [AW-1:0] buf_base;

  always_comb begin
    entry_w   = AW'(entry_i);
    desc_base = base_i + RING_A + entry_w * DESC_A;
    buf_base  = base_i + BUF_A + entry_w * BSZ_A;
    case (sel_i)
      A_LENH:  addr_o = desc_base + AW'(OFS_LENH);
      A_LENL:  addr_o = desc_base + AW'(OFS_LENL);
      A_BUF:   addr_o = buf_base + AW'(boff_i);
      default: addr_o = desc_base + AW'(OFS_STAT);
    endcase
  end
endmodule

// File: rtl/txr_len_decode.sv
module txr_len_decode import txr_pkg::*; #(
  parameter int BUF_BYTES = 1544
) (
  input  logic [7:0]       hi_i,
  input  logic [7:0]       lo_i,
  output logic [LEN_W-1:0] cnt_o
);
  localparam logic [LEN_W-1:0] LIMIT = LEN_W'(BUF_BYTES);

  logic [LEN_W-1:0] neg_len;
  logic [LEN_W-1:0] raw_cnt;

  always_comb begin
    neg_len = {hi_i, lo_i};
    raw_cnt = ~neg_len + LEN_W'(1);
    if (raw_cnt == '0 || raw_cnt > LIMIT) cnt_o = LIMIT;
    else                                  cnt_o = raw_cnt;
  end
endmodule

// File: rtl/txr_byte_out.sv
module txr_byte_out (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       first_i,
  input  logic       last_i,
  input  logic       ready_i,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       first_o,
  output logic       last_o,
  output logic       accept_o
);
  assign accept_o = valid_o & ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      first_o <= 1'b0;
      last_o  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      first_o <= first_i;
      last_o  <= last_i;
    end else if (accept_o) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/txr_engine.sv
module txr_engine import txr_pkg::*; #(
  parameter int AW         = 24,
  parameter int RING_LOG   = 4,
  parameter int DESC_BYTES = 8,
  parameter int RING_OFS   = 152,
  parameter int BUF_OFS    = 280,
  parameter int BUF_BYTES  = 1544
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trig_i,
  input  logic                stopped_i,
  input  logic [AW-1:0]       base_i,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic [7:0]          mem_wdata_o,
  input  logic                mem_rvalid_i,
  input  logic [7:0]          mem_rdata_i,
  output logic                tx_valid_o,
  output logic [7:0]          tx_data_o,
  output logic                tx_first_o,
  output logic                tx_last_o,
  input  logic                tx_ready_i,
  output logic                tint_o,
  output logic                busy_o,
  output logic [RING_LOG-1:0] idx_o
);
  walk_state_t         st;
  logic [RING_LOG-1:0] walk, walk_nx, stop_at, idx_q;
  logic [7:0]          len_hi;
  logic [LEN_W-1:0]    cnt, bcnt, dec_cnt;
  logic                busy_q, req_q, we_q, tint_q;
  logic [7:0]          wdata_q;
  logic [AW-1:0]       addr_q, gen_addr;
  addr_sel_t           sel;
  logic                out_load, out_acc;

  assign walk_nx = walk + 1'b1;

  always_comb begin
    case (st)
      S_LENH_RQ: sel = A_LENH;
      S_LENL_RQ: sel = A_LENL;
      S_BYTE_RQ: sel = A_BUF;
      default:   sel = A_STAT;
    endcase
  end

  txr_addr_gen #(
    .AW(AW), .RING_LOG(RING_LOG), .DESC_BYTES(DESC_BYTES),
    .RING_OFS(RING_OFS), .BUF_OFS(BUF_OFS), .BUF_BYTES(BUF_BYTES)
  ) u_addr (
    .base_i(base_i), .entry_i(walk), .sel_i(sel), .boff_i(bcnt), .addr_o(gen_addr)
  );

  txr_len_decode #(.BUF_BYTES(BUF_BYTES)) u_len (
    .hi_i(len_hi), .lo_i(mem_rdata_i), .cnt_o(dec_cnt)
  );

  assign out_load = (st == S_BYTE_WT) && mem_rvalid_i;

  txr_byte_out u_out (
    .clk(clk), .rst(rst), .load_i(out_load), .data_i(mem_rdata_i),
    .first_i(bcnt == '0), .last_i(bcnt == cnt - LEN_W'(1)), .ready_i(tx_ready_i),
    .valid_o(tx_valid_o), .data_o(tx_data_o), .first_o(tx_first_o),
    .last_o(tx_last_o), .accept_o(out_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      walk    <= '0;
      stop_at <= '0;
      idx_q   <= '0;
      len_hi  <= '0;
      cnt     <= '0;
      bcnt    <= '0;
      busy_q  <= 1'b0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      addr_q  <= '0;
      tint_q  <= 1'b0;
    end else begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      tint_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (trig_i && !stopped_i) begin
            walk    <= idx_q;
            stop_at <= idx_q - 1'b1;
            busy_q  <= 1'b1;
            st      <= S_STAT_RQ;
          end
        end
        S_STAT_RQ: begin
          req_q  <= 1'b1;
          addr_q <= gen_addr;
          st     <= S_STAT_WT;
        end
        S_STAT_WT: begin
          if (mem_rvalid_i) st <= (mem_rdata_i == READY_CODE) ? S_LENH_RQ : S_STEP;
        end
        S_LENH_RQ: begin
          req_q  <= 1'b1;
          addr_q <= gen_addr;
          st     <= S_LENH_WT;
        end
        S_LENH_WT: begin
          if (mem_rvalid_i) begin
            len_hi <= mem_rdata_i;
            st     <= S_LENL_RQ;
          end
        end
        S_LENL_RQ: begin
          req_q  <= 1'b1;
          addr_q <= gen_addr;
          st     <= S_LENL_WT;
        end
        S_LENL_WT: begin
          if (mem_rvalid_i) begin
            cnt  <= dec_cnt;
            bcnt <= '0;
            st   <= S_BYTE_RQ;
          end
        end
        S_BYTE_RQ: begin
          req_q  <= 1'b1;
          addr_q <= gen_addr;
          st     <= S_BYTE_WT;
        end
        S_BYTE_WT: begin
          if (mem_rvalid_i) st <= S_BYTE_OUT;
        end
        S_BYTE_OUT: begin
          if (out_acc) begin
            if (tx_last_o) st <= S_REL_RQ;
            else begin
              bcnt <= bcnt + LEN_W'(1);
              st   <= S_BYTE_RQ;
            end
          end
        end
        S_REL_RQ: begin
          req_q   <= 1'b1;
          we_q    <= 1'b1;
          wdata_q <= DONE_CODE;
          addr_q  <= gen_addr;
          st      <= S_REL_WT;
        end
        S_REL_WT: begin
          if (mem_rvalid_i) begin
            tint_q <= 1'b1;
            idx_q  <= idx_q + 1'b1;
            st     <= S_STEP;
          end
        end
        S_STEP: begin
          if (walk_nx == stop_at) begin
            busy_q <= 1'b0;
            st     <= S_IDLE;
          end else begin
            walk <= walk_nx;
            st   <= S_STAT_RQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;
  assign tint_o      = tint_q;
  assign busy_o      = busy_q;
  assign idx_o       = idx_q;
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk #(
  parameter int RING_LOG = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                stopped_i,
  input logic                mem_req_o,
  input logic                mem_we_o,
  input logic [7:0]          mem_wdata_o,
  input logic                tx_valid_o,
  input logic [7:0]          tx_data_o,
  input logic                tx_first_o,
  input logic                tx_last_o,
  input logic                tx_ready_i,
  input logic                tint_o,
  input logic                busy_o,
  input logic [RING_LOG-1:0] idx_o
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!busy_o && !tx_valid_o && !mem_req_o && !tint_o && idx_o == '0));

  assert_hold_in_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && !tx_ready_i) |=>
      (tx_valid_o && $stable(tx_data_o) && $stable(tx_first_o) && $stable(tx_last_o)));

  assert_no_fetch_in_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && !tx_ready_i) |-> !mem_req_o);

  assert_done_code_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o == 8'h03));

  assert_tint_step_R6: assert property (@(posedge clk) disable iff (rst)
    tint_o |-> (idx_o == RING_LOG'($past(idx_o) + 1'b1)));

  assert_tint_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    tint_o |=> !tint_o);

  assert_stopped_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && stopped_i) |=> !busy_o);
endmodule

bind txr_engine txr_engine_chk #(.RING_LOG(RING_LOG)) u_chk (
  .clk(clk), .rst(rst), .stopped_i(stopped_i), .mem_req_o(mem_req_o),
  .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .tx_valid_o(tx_valid_o),
  .tx_data_o(tx_data_o), .tx_first_o(tx_first_o), .tx_last_o(tx_last_o),
  .tx_ready_i(tx_ready_i), .tint_o(tint_o), .busy_o(busy_o), .idx_o(idx_o)
);

// File: tb/sim_txr_engine.sv
`timescale 1ns/1ps
module sim_txr_engine;
  localparam int AW = 24;
  localparam int BASE = 256;
  localparam int RING_OFS = 152;
  localparam int BUF_OFS = 280;
  localparam int BUF_BYTES = 1544;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0;
  logic stopped = 1'b0;
  logic mem_req, mem_we, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata = 8'h00;
  logic tx_valid, tx_first, tx_last, tint, busy;
  logic tx_ready = 1'b1;
  logic [7:0] tx_data;
  logic [3:0] idx;

  always #4 clk = ~clk;

  txr_engine u0 (
    .clk(clk), .rst(rst), .trig_i(trig), .stopped_i(stopped), .base_i(AW'(BASE)),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_first_o(tx_first), .tx_last_o(tx_last),
    .tx_ready_i(tx_ready), .tint_o(tint), .busy_o(busy), .idx_o(idx)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] desc_mem [0:127];
  logic tb_we = 1'b0;
  int tb_a = 0;
  logic [7:0] tb_d = 8'h00;
  bit stall_en = 1'b0;

  logic [7:0] cap_data [0:8191];
  bit cap_first [0:8191];
  bit cap_last [0:8191];
  int cap_n = 0, req_cnt = 0, tint_cnt = 0, busy_seen = 0;
  int stall_seen = 0, stall_bad = 0, stall_req = 0;
  bit stl_prev = 1'b0, stl_f, stl_l;
  logic [7:0] stl_d;

  int exp_e [0:7];
  int exp_n [0:7];
  int n_exp = 0;

  function automatic logic [7:0] pat(input int e, input int j);
    int v;
    v = e * 37 + j * 7 + 1;
    return v[7:0];
  endfunction

  function automatic logic [7:0] rd(input int a0);
    int a;
    a = a0 - BASE;
    if (a >= BUF_OFS) return pat((a - BUF_OFS) / BUF_BYTES, (a - BUF_OFS) % BUF_BYTES);
    else if (a >= RING_OFS) return desc_mem[a - RING_OFS];
    else return 8'hEE;
  endfunction

  // memory model: one response per request, one cycle later
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (tb_we) desc_mem[tb_a] <= tb_d;
    if (mem_req) begin
      mem_rvalid <= 1'b1;
      if (mem_we) begin
        if (int'(mem_addr) - BASE >= RING_OFS && int'(mem_addr) - BASE < BUF_OFS)
          desc_mem[int'(mem_addr) - BASE - RING_OFS] <= mem_wdata;
      end else begin
        mem_rdata <= rd(int'(mem_addr));
      end
    end
  end

  always @(posedge clk) begin
    #1;
    tx_ready = stall_en ? (cyc % 3 != 2) : 1'b1;
  end

  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      if (cap_n < 8192) begin
        cap_data[cap_n] = tx_data;
        cap_first[cap_n] = tx_first;
        cap_last[cap_n] = tx_last;
      end
      cap_n++;
    end
    if (mem_req) req_cnt++;
    if (tint) tint_cnt++;
    if (busy) busy_seen++;
    if (mem_req && tx_valid && !tx_ready) stall_req++;
    if (stl_prev && !(tx_valid && tx_data == stl_d && tx_first == stl_f && tx_last == stl_l))
      stall_bad++;
    stl_prev = tx_valid && !tx_ready;
    if (stl_prev) begin
      stall_seen++;
      stl_d = tx_data;
      stl_f = tx_first;
      stl_l = tx_last;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic dwr(input int off, input logic [7:0] v);
    tb_we = 1'b1; tb_a = off; tb_d = v;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic set_entry(input int e, input logic [7:0] status, input int count);
    logic [15:0] neg;
    neg = 16'(-count);
    dwr(e * 8 + 2, status);
    dwr(e * 8 + 4, neg[15:8]);
    dwr(e * 8 + 5, neg[7:0]);
  endtask

  task automatic clear_ring();
    for (int e = 0; e < 16; e++) dwr(e * 8 + 2, 8'h00);
  endtask

  task automatic clr_mon();
    cap_n = 0; req_cnt = 0; tint_cnt = 0; busy_seen = 0;
    stall_seen = 0; stall_bad = 0; stall_req = 0; n_exp = 0;
  endtask

  task automatic add_exp(input int e, input int n);
    exp_e[n_exp] = e; exp_n[n_exp] = n; n_exp++;
  endtask

  task automatic kick();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (busy && n < 60000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_stream(input string tag);
    int pos, tot;
    tot = 0;
    for (int f = 0; f < n_exp; f++) tot += exp_n[f];
    chk(cap_n == tot, tag, "streamed byte count", cap_n, tot);
    pos = 0;
    for (int f = 0; f < n_exp; f++) begin
      int bad_at;
      bad_at = -1;
      for (int j = 0; j < exp_n[f]; j++) begin
        int p;
        p = pos + j;
        if (p >= cap_n || p > 8191) begin
          if (bad_at < 0) bad_at = j;
        end else if (cap_data[p] !== pat(exp_e[f], j) || cap_first[p] != (j == 0) ||
                     cap_last[p] != (j == exp_n[f] - 1)) begin
          if (bad_at < 0) bad_at = j;
        end
      end
      chk(bad_at < 0, tag, $sformatf("entry %0d first wrong byte", exp_e[f]), bad_at, -1);
      pos += exp_n[f];
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !tx_valid && !mem_req && !tint && idx == 0, "R1", "quiet in reset",
        {busy, tx_valid, mem_req, tint}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !tx_valid && !mem_req && idx == 0, "R1", "quiet after reset",
        {busy, tx_valid, mem_req}, 0);
  endtask

  task automatic t_single();
    clear_ring();
    clr_mon();
    set_entry(0, 8'h83, 5);
    add_exp(0, 5);
    kick();
    wait_idle();
    check_stream("R3 R5");
    chk(desc_mem[2] == 8'h03, "R6 R10", "status after send", desc_mem[2], 3);
    chk(tint_cnt == 1, "R6", "tint pulses", tint_cnt, 1);
    chk(idx == 1, "R6", "index after send", idx, 1);
  endtask

  task automatic t_notready();
    logic [7:0] codes [0:4];
    codes[0] = 8'h80; codes[1] = 8'h82; codes[2] = 8'h93; codes[3] = 8'h03; codes[4] = 8'h87;
    clear_ring();
    clr_mon();
    for (int k = 0; k < 5; k++) set_entry(k + 1, codes[k], 4);
    set_entry(6, 8'h83, 3);
    add_exp(6, 3);
    kick();
    wait_idle();
    check_stream("R2");
    for (int k = 0; k < 5; k++)
      chk(desc_mem[(k + 1) * 8 + 2] == codes[k], "R2", $sformatf("skipped status of entry %0d", k + 1),
          desc_mem[(k + 1) * 8 + 2], codes[k]);
    chk(desc_mem[6 * 8 + 2] == 8'h03, "R6", "status of sent entry", desc_mem[50], 3);
    chk(idx == 2, "R9", "index counts sent entries", idx, 2);
  endtask

  task automatic t_multi();
    clear_ring();
    clr_mon();
    set_entry(2, 8'h83, 4);
    set_entry(9, 8'h83, 6);
    set_entry(0, 8'h83, 2);
    set_entry(1, 8'h83, 3);
    add_exp(2, 4);
    add_exp(9, 6);
    add_exp(0, 2);
    stall_en = 1'b1;
    kick();
    wait_idle();
    stall_en = 1'b0;
    check_stream("R7");
    chk(desc_mem[1 * 8 + 2] == 8'h83, "R7", "entry before start untouched", desc_mem[10], 8'h83);
    chk(tint_cnt == 3, "R7", "entries sent in pass", tint_cnt, 3);
    chk(idx == 5, "R9", "index after pass", idx, 5);
    chk(stall_seen > 0, "R5", "sink stalls occurred", stall_seen, 1);
    chk(stall_bad == 0, "R5", "byte changed during stall", stall_bad, 0);
    chk(stall_req == 0, "R5", "fetch during stall", stall_req, 0);
  endtask

  task automatic t_clamp();
    clear_ring();
    clr_mon();
    set_entry(5, 8'h83, 0);
    set_entry(6, 8'h83, 2000);
    set_entry(7, 8'h83, 1544);
    set_entry(8, 8'h83, 1);
    add_exp(5, 1544);
    add_exp(6, 1544);
    add_exp(7, 1544);
    add_exp(8, 1);
    kick();
    wait_idle();
    check_stream("R4");
    chk(idx == 9, "R4", "index after clamp pass", idx, 9);
  endtask

  task automatic t_stop();
    clear_ring();
    clr_mon();
    set_entry(9, 8'h83, 40);
    stopped = 1'b1;
    kick();
    repeat (20) @(negedge clk);
    chk(busy_seen == 0, "R8", "busy while stopped", busy_seen, 0);
    chk(req_cnt == 0, "R8", "requests while stopped", req_cnt, 0);
    chk(desc_mem[9 * 8 + 2] == 8'h83 && tint_cnt == 0, "R8", "entry untouched while stopped",
        desc_mem[74], 8'h83);
    stopped = 1'b0;
    add_exp(9, 40);
    kick();
    repeat (10) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    wait_idle();
    req_cnt = 0;
    repeat (40) @(negedge clk);
    chk(req_cnt == 0 && !busy, "R8", "no pass from trigger while busy", req_cnt, 0);
    check_stream("R8");
    chk(idx == 10, "R8", "index after resumed pass", idx, 10);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) desc_mem[i] = 8'h00;
    t_reset();
    t_single();
    t_notready();
    t_multi();
    t_clamp();
    t_stop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule